// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Host Register File

This block is a chipset-style watchdog. A host programs it through a small register file on a simple synchronous bus: a word address, a write enable and a 16-bit write data bus. Reads are combinational from the address. A down-counter is reloaded from a programmable timeout value and counts down by one on each pulse of a tick-enable input. The integration supplies that pulse at the chosen tick period; one tick is nominally 0.6 s, so a timeout of S seconds is programmed as S*10/6 ticks.

The first expiry only raises a timeout flag and reloads the counter, so the next expiry comes one full period later. When that flag is enabled, an interrupt request output can follow it. If the counter expires again while software has still not cleared the flag, the block records a second-timeout event and a boot event. Unless the no-reboot strap input is high, it also emits a one-cycle reboot pulse.

The register file also holds the halt and lock controls, two write-one-to-clear status words, two mailbox bytes that flag status when software writes them, and a few general-purpose control and message words with fixed reset values.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the register reads are: address 7 (timeout) 0x0004, address 6 (control 2) 0x0008, address 9 (interrupt-generation byte) 0x0003, and every other address from 0 to 9 reads 0; `reboot_o` and `irq_o` are low.
- R2: Any write to address 0 loads the counter with the timeout value, or with 1 if the timeout is 0; a read of address 0 returns the current count.
- R3: While not halted, the count decreases by exactly one on each cycle with `tick_en` high, and does not change on cycles without it.
- R4: With a timeout of N, the count reads 1 and status-1 bit 3 (timeout) is still clear after N-1 ticks. On the Nth tick bit 3 is set and the count reloads to N.
- R5: The timeout register (address 7) keeps only its low 10 bits, so writing 0xFFFF reads back 0x03FF.
- R6: While control-1 (address 5) bit 11 (halt) is set, ticks leave the count unchanged. Clearing the bit resumes counting from the held value.
- R7: An expiry while status-1 bit 3 is set sets status-2 (address 4) bit 1 (second timeout) and bit 2 (boot). If `no_reboot_i` is low, `reboot_o` is also high for exactly the one cycle after that tick. If `no_reboot_i` is high, no pulse is emitted.
- R8: The status registers (address 3 and address 4) are write-one-to-clear. Writing zeros leaves them unchanged, and writing back a value just read leaves them at 0.
- R9: Control-1 bit 12 (lock), once written to 1, stays 1 through later writes of 0 until reset.
- R10: A write to address 1 (data-in byte) sets status-1 bit 1, and a write to address 2 (data-out byte) sets status-1 bit 2. Each byte reads back in bits 7:0 of its address.
- R11: `irq_o` is high exactly while status-1 bit 3 and control-1 bit 9 (interrupt enable) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per watchdog tick |
| no_reboot_i | input | 1 | Strap that suppresses the reboot pulse when high |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request after the first expiry |
| reboot_o | output | 1 | One-cycle reboot pulse after a second expiry |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the bench reads them back from the following low clock phase. Reads need no extra cycle because the read path is combinational. A tick is applied for one whole cycle. The count, the status bits and `irq_o` change at the edge that samples the tick and are compared in the next low phase. `reboot_o` is registered at that same edge, so the bench counts its pulses on falling edges and compares the count right after the tick that caused the second expiry. The halt, zero-timeout, masked-timeout, write-zeros and no-reboot cases each get a read in that same slot.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 4;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIN    = 4'd1;
    localparam logic [ADDR_W-1:0] A_DOUT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT1  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT2  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CTRL1  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CTRL2  = 4'd6;
    localparam logic [ADDR_W-1:0] A_TMO    = 4'd7;
    localparam logic [ADDR_W-1:0] A_MSG    = 4'd8;
    localparam logic [ADDR_W-1:0] A_SWIRQ  = 4'd9;

    // bit positions
    localparam int B_ST1_DIN  = 1;
    localparam int B_ST1_DOUT = 2;
    localparam int B_ST1_TMO  = 3;
    localparam int B_ST2_SEC  = 1;
    localparam int B_ST2_BOOT = 2;
    localparam int B_C1_IRQEN = 9;
    localparam int B_C1_HALT  = 11;
    localparam int B_C1_LOCK  = 12;

    // reset values
    localparam logic [REG_W-1:0]  CTRL2_RST = 16'h0008;
    localparam logic [BYTE_W-1:0] SWIRQ_RST = 8'h03;

    typedef struct packed {
        logic tmo;
        logic dout;
        logic din;
    } stat1_t;

    typedef struct packed {
        logic boot;
        logic second;
    } stat2_t;

    typedef struct packed {
        logic lock;
        logic halt;
        logic irq_en;
    } ctrl1_t;

    function automatic logic [REG_W-1:0] pack_stat1(input stat1_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_ST1_TMO]  = s.tmo;
        v[B_ST1_DOUT] = s.dout;
        v[B_ST1_DIN]  = s.din;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat2(input stat2_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_ST2_SEC]  = s.second;
        v[B_ST2_BOOT] = s.boot;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl1(input ctrl1_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_C1_LOCK]  = c.lock;
        v[B_C1_HALT]  = c.halt;
        v[B_C1_IRQEN] = c.irq_en;
        return v;
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             load,
    input  logic [CNT_W-1:0] tmo_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] start_val;
    logic             advance;

    // zero timeout behaves as a single tick
    assign start_val = (tmo_val == '0) ? ONE : tmo_val;
    assign advance   = tick_en && !halt && !load;
    assign expire    = advance && (count <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= start_val;
        end else if (advance) begin
            if (count <= ONE) begin
                count <= start_val;
            end else begin
                count <= count - ONE;
            end
        end
    end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic first_pending,
    input  logic no_reboot_i,
    output logic set_first,
    output logic set_second,
    output logic reboot_o
);
    assign set_first  = expire && !first_pending;
    assign set_second = expire && first_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            reboot_o <= 1'b0;
        end else begin
            reboot_o <= set_second && !no_reboot_i;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              set_first,
    input  logic              set_second,
    output logic [CNT_W-1:0]  tmo_val,
    output logic              load,
    output ctrl1_t            ctrl1,
    output stat1_t            stat1,
    output stat2_t            stat2
);
    localparam logic [CNT_W-1:0] TMO_RST = CNT_W'(4);

    logic [BYTE_W-1:0] din_q;
    logic [BYTE_W-1:0] dout_q;
    logic [REG_W-1:0]  ctrl2_q;
    logic [REG_W-1:0]  msg_q;
    logic [BYTE_W-1:0] swirq_q;
    logic              wr_din;
    logic              wr_dout;

    assign load    = bus_we && (bus_addr == A_RELOAD);
    assign wr_din  = bus_we && (bus_addr == A_DIN);
    assign wr_dout = bus_we && (bus_addr == A_DOUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q   <= '0;
            dout_q  <= '0;
            ctrl2_q <= CTRL2_RST;
            msg_q   <= '0;
            swirq_q <= SWIRQ_RST;
            tmo_val <= TMO_RST;
            ctrl1   <= '0;
            stat1   <= '0;
            stat2   <= '0;
        end else begin
            if (bus_we) begin
                unique case (bus_addr)
                    A_DIN:   din_q   <= bus_wdata[BYTE_W-1:0];
                    A_DOUT:  dout_q  <= bus_wdata[BYTE_W-1:0];
                    A_CTRL2: ctrl2_q <= bus_wdata;
                    A_MSG:   msg_q   <= bus_wdata;
                    A_SWIRQ: swirq_q <= bus_wdata[BYTE_W-1:0];
                    A_TMO:   tmo_val <= bus_wdata[CNT_W-1:0];
                    A_CTRL1: begin
                        ctrl1.halt   <= bus_wdata[B_C1_HALT];
                        ctrl1.irq_en <= bus_wdata[B_C1_IRQEN];
                        ctrl1.lock   <= ctrl1.lock | bus_wdata[B_C1_LOCK];
                    end
                    A_STAT1: begin
                        stat1.tmo  <= stat1.tmo  & ~bus_wdata[B_ST1_TMO];
                        stat1.dout <= stat1.dout & ~bus_wdata[B_ST1_DOUT];
                        stat1.din  <= stat1.din  & ~bus_wdata[B_ST1_DIN];
                    end
                    A_STAT2: begin
                        stat2.second <= stat2.second & ~bus_wdata[B_ST2_SEC];
                        stat2.boot   <= stat2.boot   & ~bus_wdata[B_ST2_BOOT];
                    end
                    default: ;
                endcase
            end
            // set events override a same-cycle clear
            if (set_first)  stat1.tmo  <= 1'b1;
            if (wr_din)     stat1.din  <= 1'b1;
            if (wr_dout)    stat1.dout <= 1'b1;
            if (set_second) begin
                stat2.second <= 1'b1;
                stat2.boot   <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_RELOAD: bus_rdata = {{(REG_W-CNT_W){1'b0}}, count};
            A_DIN:    bus_rdata = {{(REG_W-BYTE_W){1'b0}}, din_q};
            A_DOUT:   bus_rdata = {{(REG_W-BYTE_W){1'b0}}, dout_q};
            A_STAT1:  bus_rdata = pack_stat1(stat1);
            A_STAT2:  bus_rdata = pack_stat2(stat2);
            A_CTRL1:  bus_rdata = pack_ctrl1(ctrl1);
            A_CTRL2:  bus_rdata = ctrl2_q;
            A_TMO:    bus_rdata = {{(REG_W-CNT_W){1'b0}}, tmo_val};
            A_MSG:    bus_rdata = msg_q;
            A_SWIRQ:  bus_rdata = {{(REG_W-BYTE_W){1'b0}}, swirq_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              no_reboot_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              reboot_o
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] tmo_val;
    logic             load;
    logic             expire;
    logic             set_first;
    logic             set_second;
    ctrl1_t           ctrl1;
    stat1_t           stat1;
    stat2_t           stat2;

    wdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count      (count),
        .set_first  (set_first),
        .set_second (set_second),
        .tmo_val    (tmo_val),
        .load       (load),
        .ctrl1      (ctrl1),
        .stat1      (stat1),
        .stat2      (stat2)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .halt    (ctrl1.halt),
        .load    (load),
        .tmo_val (tmo_val),
        .count   (count),
        .expire  (expire)
    );

    wdt_escalate esc_i (
        .clk           (clk),
        .rst           (rst),
        .expire        (expire),
        .first_pending (stat1.tmo),
        .no_reboot_i   (no_reboot_i),
        .set_first     (set_first),
        .set_second    (set_second),
        .reboot_o      (reboot_o)
    );

    assign irq_o = stat1.tmo && ctrl1.irq_en;
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             no_reboot_i,
    input logic             reboot_o,
    input logic             irq_o,
    input logic             halt,
    input logic             load,
    input logic             lock,
    input logic             tmo_sts,
    input logic             second_sts,
    input logic [CNT_W-1:0] count
);
    // R9: lock stays set once written
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    // R6: halted counter holds its value unless reloaded
    assert_halt_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(count));

    // R2: a reload never leaves the counter at zero
    assert_reload_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (count != '0));

    // R7: reboot pulse only with second-timeout recorded and strap low
    assert_reboot_second_R7: assert property (@(posedge clk) disable iff (rst)
        reboot_o |-> second_sts);

    assert_reboot_strap_R7: assert property (@(posedge clk) disable iff (rst)
        reboot_o |-> $past(!no_reboot_i));

    // R11: interrupt only while the first timeout flag is pending
    assert_irq_flag_R11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> tmo_sts);
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .no_reboot_i (no_reboot_i),
    .reboot_o    (reboot_o),
    .irq_o       (irq_o),
    .halt        (ctrl1.halt),
    .load        (load),
    .lock        (ctrl1.lock),
    .tmo_sts     (stat1.tmo),
    .second_sts  (stat2.second),
    .count       (count)
);

// File: tb/wdt_twostage_tb_top.sv
module wdt_twostage_tb_top;
    localparam int CLK_P = 10;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    localparam logic [3:0] RLD = 4'd0, DIN = 4'd1, DOUT = 4'd2, ST1 = 4'd3,
                           ST2 = 4'd4, C1 = 4'd5, C2 = 4'd6, TMO = 4'd7,
                           MSG = 4'd8, SWI = 4'd9;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, TMO, 16'h0006, 16'h0000, 8'd5},
        '{OP_RD, TMO, 16'h0000, 16'h0006, 8'd5},   // R5 plain value
        '{OP_WR, C1,  16'h0800, 16'h0000, 8'd6},   // halt
        '{OP_WR, RLD, 16'h0000, 16'h0000, 8'd2},
        '{OP_RD, RLD, 16'h0000, 16'h0006, 8'd2},   // R2 load
        '{OP_TK, RLD, 16'd3,    16'h0000, 8'd6},
        '{OP_RD, RLD, 16'h0000, 16'h0006, 8'd6},   // R6 held
        '{OP_WR, C1,  16'h0000, 16'h0000, 8'd6},
        '{OP_RD, RLD, 16'h0000, 16'h0006, 8'd3},   // R3 no tick no change
        '{OP_TK, RLD, 16'd1,    16'h0000, 8'd3},
        '{OP_RD, RLD, 16'h0000, 16'h0005, 8'd3},   // R3 one per tick
        '{OP_TK, RLD, 16'd4,    16'h0000, 8'd4},
        '{OP_RD, RLD, 16'h0000, 16'h0001, 8'd4},   // R4 N-1 ticks
        '{OP_RD, ST1, 16'h0000, 16'h0000, 8'd4},
        '{OP_TK, RLD, 16'd1,    16'h0000, 8'd4},
        '{OP_RD, ST1, 16'h0000, 16'h0008, 8'd4},   // R4 Nth tick
        '{OP_RD, RLD, 16'h0000, 16'h0006, 8'd4},   // R4 reload
        '{OP_WR, ST1, 16'h0008, 16'h0000, 8'd8},
        '{OP_RD, ST1, 16'h0000, 16'h0000, 8'd8},   // R8 clear
        '{OP_WR, DIN, 16'h005A, 16'h0000, 8'd10},
        '{OP_RD, ST1, 16'h0000, 16'h0002, 8'd10},  // R10 data-in flag
        '{OP_RD, DIN, 16'h0000, 16'h005A, 8'd10},
        '{OP_WR, DOUT,16'h00A5, 16'h0000, 8'd10},
        '{OP_RD, ST1, 16'h0000, 16'h0006, 8'd10},  // R10 data-out flag
        '{OP_WR, ST1, 16'h0000, 16'h0000, 8'd8},
        '{OP_RD, ST1, 16'h0000, 16'h0006, 8'd8},   // R8 zeros keep
        '{OP_WR, TMO, 16'hFFFF, 16'h0000, 8'd5},
        '{OP_RD, TMO, 16'h0000, 16'h03FF, 8'd5},   // R5 masked
        '{OP_WR, TMO, 16'h0000, 16'h0000, 8'd2},
        '{OP_WR, RLD, 16'h0000, 16'h0000, 8'd2},
        '{OP_RD, RLD, 16'h0000, 16'h0001, 8'd2},   // R2 zero as one
        '{OP_RD, DOUT,16'h0000, 16'h00A5, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        no_reboot_i = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        reboot_o;

    int checks = 0;
    int fails = 0;
    int reboots = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (!rst && reboot_o) reboots++;

    wdt_twostage dut_i (
        .clk (clk), .rst (rst), .tick_en (tick_en), .no_reboot_i (no_reboot_i),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_o (irq_o), .reboot_o (reboot_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), int'(e));
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset defaults
        rd(RLD, 16'h0000, "R1 reload");
        rd(DIN, 16'h0000, "R1 data-in");
        rd(DOUT,16'h0000, "R1 data-out");
        rd(ST1, 16'h0000, "R1 status1");
        rd(ST2, 16'h0000, "R1 status2");
        rd(C1,  16'h0000, "R1 control1");
        rd(C2,  16'h0008, "R1 control2");
        rd(TMO, 16'h0004, "R1 timeout");
        rd(MSG, 16'h0000, "R1 message");
        rd(SWI, 16'h0003, "R1 irq-gen");
        check("R1 irq_o", int'(irq_o), 0);
        check("R1 reboot_o", int'(reboot_o), 0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: wr(VECS[i].addr, VECS[i].data);
                OP_RD: rd(VECS[i].addr, VECS[i].exp,
                          $sformatf("R%0d vector %0d", VECS[i].req, i));
                default: tick(int'(VECS[i].data));
            endcase
        end

        // R9 lock sticky
        wr(C1, 16'h1000);
        wr(C1, 16'h0000);
        rd(C1, 16'h1000, "R9 lock after write 0");

        // R7 second expiry with strap low
        wr(TMO, 16'h0003);
        wr(ST1, 16'hFFFF);
        wr(ST2, 16'hFFFF);
        wr(RLD, 16'h0000);
        tick(2);
        rd(RLD, 16'h0001, "R4 count before expiry");
        tick(1);
        rd(ST1, 16'h0008, "R4 first expiry flag");
        rd(ST2, 16'h0000, "R7 no second yet");
        check("R7 no reboot after first", reboots, 0);
        check("R11 irq disabled", int'(irq_o), 0);
        wr(C1, 16'h0200);
        #1;
        check("R11 irq enabled", int'(irq_o), 1);
        rd(C1, 16'h1200, "R9 lock kept");
        tick(3);
        #1;
        check("R7 reboot pulse", reboots, 1);
        rd(ST2, 16'h0006, "R7 second and boot");
        check("R7 pulse one cycle", int'(reboot_o), 0);

        // R8 write back what was read
        wr(ST1, 16'h0008);
        wr(ST2, 16'h0006);
        rd(ST1, 16'h0000, "R8 status1 cleared");
        rd(ST2, 16'h0000, "R8 status2 cleared");
        check("R11 irq drops", int'(irq_o), 0);

        // R7 strap high suppresses the pulse
        no_reboot_i = 1'b1;
        wr(RLD, 16'h0000);
        tick(6);
        #1;
        rd(ST2, 16'h0006, "R7 status with strap");
        check("R7 no pulse with strap", reboots, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule